// File: doc/BRIEF.md
# Operand Address Generator for a Unified Memory

This block turns the operand field of an instruction into byte addresses in a single 64 KB memory. That memory holds code, data and both register files. Four 32-bit general registers occupy bytes 0 to 15, each at four times its index. Four 16-bit pointer registers follow at bytes 16 to 23, each at 16 plus twice its index. Register values are stored little-endian, and no separate register flops exist. An operand can name a general register or a pointer register directly. It can go through a pointer's contents, optionally bumping the pointer afterwards for strided walks. It can also give a 6-bit direct offset, which a 10-bit working-block register extends to a full address.

Once a request is accepted, the block emits one byte address per clock, starting in the next cycle. It marks the beat index and the final beat, and it reports the total byte count of the access. A post-increment access also produces a one-cycle write-back of the bumped pointer value, together with the pointer's own memory address. The surrounding memory port then stores that value. Immediate operands are consumed without any memory activity.

Top module: `opaddr_gen`

## Requirements
- R1: After reset the outputs are idle (mem_req_o, ptr_wb_o, last_o low, mem_addr_o, mem_bytes_o, beat_o zero), ready_o is high and the block register holds 0.
- R2: Mode code 0 (general register) starts at byte 4·idx_i; the byte count follows width_i: 0 gives 1, 1 gives 2, 2 or 3 give 4.
- R3: Mode code 1 (pointer register) starts at byte 16 + 2·idx_i and always moves 2 bytes, whatever width_i says.
- R4: Mode code 2 (pointer-indirect) starts at ptr_val_i, moves the width_i byte count and produces no pointer write-back.
- R5: Mode code 3 (pointer-indirect with post-increment) addresses like R4. In the cycle after acceptance, ptr_wb_o is high for exactly one cycle, ptr_wb_addr_o = 16 + 2·idx_i and ptr_wb_val_o = (ptr_val_i + byte count) mod 65536. At all other times ptr_wb_o, ptr_wb_addr_o and ptr_wb_val_o are low or zero.
- R6: Mode code 4 (direct) starts at {block[9:0], dir_off_i[5:0]} with the width_i byte count.
- R7: blk_we_i loads blk_val_i into the block register in any cycle, busy or not. A direct request in the same cycle as the write already uses the new value.
- R8: Mode codes 5, 6 and 7 (immediate) are accepted but raise neither mem_req_o nor ptr_wb_o, and leave the outputs idle.
- R9: Beats start in the cycle after acceptance. The address rises by one per cycle modulo 65536, beat_o counts 0, 1, … and last_o is high on the final beat only. mem_bytes_o holds the count throughout the access.
- R10: ready_o is low while a beat other than the final one is being presented. A request offered while ready_o is low is ignored.
- R11: A request accepted during the final beat of an access presents its first beat in the very next cycle, without an idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Operand request offered |
| ready_o | output | 1 | Request is taken at this edge when high |
| mode_i | input | 3 | Addressing mode code |
| idx_i | input | 2 | General or pointer register index |
| dir_off_i | input | 6 | Direct offset inside the working block |
| width_i | input | 2 | Data width code |
| ptr_val_i | input | 16 | Contents of the pointer register named by idx_i |
| blk_we_i | input | 1 | Load the working-block register |
| blk_val_i | input | 10 | New working-block value |
| mem_req_o | output | 1 | A byte beat is presented |
| mem_addr_o | output | 16 | Byte address of the current beat |
| mem_bytes_o | output | 3 | Total bytes of the current access |
| beat_o | output | 2 | Index of the current beat |
| last_o | output | 1 | Current beat is the final one |
| ptr_wb_o | output | 1 | Bumped pointer write-back valid |
| ptr_wb_addr_o | output | 16 | Memory address of the bumped pointer |
| ptr_wb_val_o | output | 16 | Bumped pointer value |

## Verification
The properties assume that a request is accepted only when req_valid_i and ready_o are both high. They also assume that ptr_val_i really is the pointer named by idx_i in the acceptance cycle, and that mode and width are stable inside that cycle. The stimulus changes inputs only at the falling edge. It keeps a request asserted until the reference model shows it was accepted, so held requests during busy beats exercise the ignore rule. Mode codes 6 and 7 and width code 3 are included on purpose, both in directed cases and in the random phase.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  typedef enum logic [2:0] {
    MODE_GREG = 3'd0,
    MODE_PREG = 3'd1,
    MODE_PIND = 3'd2,
    MODE_PINC = 3'd3,
    MODE_DIR  = 3'd4,
    MODE_IMM  = 3'd5
  } amode_e;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2
  } awidth_e;
endpackage

// File: rtl/opaddr_blk_reg.sv
module opaddr_blk_reg #(
  parameter int BLK_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BLK_W-1:0] val,
  output logic [BLK_W-1:0] blk_eff
);
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (rst)     blk_q <= '0;
    else if (we) blk_q <= val;
  end

  // a write in the same cycle already steers a direct address
  assign blk_eff = we ? val : blk_q;
endmodule

// File: rtl/opaddr_base_calc.sv
module opaddr_base_calc
  import opaddr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 6,
  parameter int NREG       = 4,
  parameter int GREG_BYTES = 4,
  parameter int PREG_BYTES = 2,
  localparam int BLK_W     = ADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(NREG),
  localparam int CNT_W     = $clog2(GREG_BYTES + 1)
) (
  input  logic [2:0]        mode,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        width,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [BLK_W-1:0]  blk,
  output logic [ADDR_W-1:0] base,
  output logic [CNT_W-1:0]  cnt,
  output logic              needs_mem,
  output logic              post_inc,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [ADDR_W-1:0] wb_val
);
  localparam logic [ADDR_W-1:0] PREG_BASE = ADDR_W'(NREG * GREG_BYTES);

  logic [CNT_W-1:0]  wbytes;
  logic [ADDR_W-1:0] greg_addr;
  logic [ADDR_W-1:0] preg_addr;

  always_comb begin
    case (width)
      WID_BYTE: wbytes = CNT_W'(1);
      WID_HALF: wbytes = CNT_W'(2);
      default:  wbytes = CNT_W'(GREG_BYTES);
    endcase
  end

  assign greg_addr = ADDR_W'(idx) * ADDR_W'(GREG_BYTES);
  assign preg_addr = PREG_BASE + ADDR_W'(idx) * ADDR_W'(PREG_BYTES);

  always_comb begin
    base      = '0;
    cnt       = wbytes;
    needs_mem = 1'b1;
    post_inc  = 1'b0;
    case (mode)
      MODE_GREG: base = greg_addr;
      MODE_PREG: begin
        base = preg_addr;
        cnt  = CNT_W'(PREG_BYTES);
      end
      MODE_PIND: base = ptr;
      MODE_PINC: begin
        base     = ptr;
        post_inc = 1'b1;
      end
      MODE_DIR:  base = {blk, off};
      default: begin
        needs_mem = 1'b0;
        cnt       = '0;
      end
    endcase
  end

  assign wb_addr = preg_addr;
  assign wb_val  = ptr + ADDR_W'(wbytes);
endmodule

// File: rtl/opaddr_beat_seq.sv
module opaddr_beat_seq #(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 3,
  parameter int BEAT_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load_mem,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  cnt,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  bytes,
  output logic [BEAT_W-1:0] beat,
  output logic              last,
  output logic              ready
);
  assign last  = active && ((CNT_W'(beat) + CNT_W'(1)) == bytes);
  assign ready = !active || last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      addr   <= '0;
      bytes  <= '0;
      beat   <= '0;
    end else if (start) begin
      active <= load_mem;
      addr   <= load_mem ? base : '0;
      bytes  <= load_mem ? cnt : '0;
      beat   <= '0;
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        addr   <= '0;
        bytes  <= '0;
        beat   <= '0;
      end else begin
        addr <= addr + ADDR_W'(1);
        beat <= beat + BEAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 6,
  parameter int NREG       = 4,
  parameter int GREG_BYTES = 4,
  parameter int PREG_BYTES = 2,
  localparam int BLK_W     = ADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(NREG),
  localparam int CNT_W     = $clog2(GREG_BYTES + 1),
  localparam int BEAT_W    = $clog2(GREG_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  output logic              ready_o,
  input  logic [2:0]        mode_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  dir_off_i,
  input  logic [1:0]        width_i,
  input  logic [ADDR_W-1:0] ptr_val_i,
  input  logic              blk_we_i,
  input  logic [BLK_W-1:0]  blk_val_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CNT_W-1:0]  mem_bytes_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o,
  output logic              ptr_wb_o,
  output logic [ADDR_W-1:0] ptr_wb_addr_o,
  output logic [ADDR_W-1:0] ptr_wb_val_o
);
  logic [BLK_W-1:0]  blk_eff;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  cnt;
  logic              needs_mem;
  logic              post_inc;
  logic [ADDR_W-1:0] wb_addr;
  logic [ADDR_W-1:0] wb_val;
  logic              start;

  opaddr_blk_reg #(.BLK_W(BLK_W)) blk_i (
    .clk     (clk),
    .rst     (rst),
    .we      (blk_we_i),
    .val     (blk_val_i),
    .blk_eff (blk_eff)
  );

  opaddr_base_calc #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NREG(NREG),
    .GREG_BYTES(GREG_BYTES), .PREG_BYTES(PREG_BYTES)
  ) calc_i (
    .mode      (mode_i),
    .idx       (idx_i),
    .off       (dir_off_i),
    .width     (width_i),
    .ptr       (ptr_val_i),
    .blk       (blk_eff),
    .base      (base),
    .cnt       (cnt),
    .needs_mem (needs_mem),
    .post_inc  (post_inc),
    .wb_addr   (wb_addr),
    .wb_val    (wb_val)
  );

  assign start = req_valid_i && ready_o;

  opaddr_beat_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .load_mem (needs_mem),
    .base     (base),
    .cnt      (cnt),
    .active   (mem_req_o),
    .addr     (mem_addr_o),
    .bytes    (mem_bytes_o),
    .beat     (beat_o),
    .last     (last_o),
    .ready    (ready_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_wb_o      <= 1'b0;
      ptr_wb_addr_o <= '0;
      ptr_wb_val_o  <= '0;
    end else begin
      ptr_wb_o      <= start && post_inc;
      ptr_wb_addr_o <= (start && post_inc) ? wb_addr : '0;
      ptr_wb_val_o  <= (start && post_inc) ? wb_val : '0;
    end
  end
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk
  import opaddr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 6,
  parameter int NREG   = 4,
  parameter int GREG_BYTES = 4,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic              ready_o,
  input logic [2:0]        mode_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [OFF_W-1:0]  dir_off_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [CNT_W-1:0]  mem_bytes_o,
  input logic [BEAT_W-1:0] beat_o,
  input logic              last_o,
  input logic              ptr_wb_o,
  input logic [ADDR_W-1:0] ptr_wb_val_o
);
  localparam logic [ADDR_W-1:0] PREG_BASE = ADDR_W'(NREG * GREG_BYTES);
  logic accept;
  assign accept = req_valid_i && ready_o;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !last_o |=> mem_req_o && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R9
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !last_o |=> beat_o == $past(beat_o) + BEAT_W'(1)); // R9
  AST_LAST_BEAT: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && last_o |-> (CNT_W'(beat_o) + CNT_W'(1)) == mem_bytes_o); // R9
  AST_LEGAL_COUNT: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> $countones(mem_bytes_o) == 1); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !last_o |-> !ready_o); // R10
  AST_IMM_SILENT: assert property (@(posedge clk) disable iff (rst)
    accept && mode_i >= 3'd5 |=> !mem_req_o && !ptr_wb_o); // R8
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (rst)
    accept && mode_i == MODE_PINC |=> ptr_wb_o); // R5
  AST_NO_STRAY_WB: assert property (@(posedge clk) disable iff (rst)
    !(accept && mode_i == MODE_PINC) |=> !ptr_wb_o); // R5
  AST_WB_VALUE: assert property (@(posedge clk) disable iff (rst)
    ptr_wb_o |-> ptr_wb_val_o == mem_addr_o + ADDR_W'(mem_bytes_o)); // R5
  AST_REG_WINDOW: assert property (@(posedge clk) disable iff (rst)
    accept && mode_i == MODE_GREG |=> mem_req_o && mem_addr_o < PREG_BASE); // R2
  AST_DIR_OFFSET: assert property (@(posedge clk) disable iff (rst)
    accept && mode_i == MODE_DIR |=> mem_addr_o[OFF_W-1:0] == $past(dir_off_i)); // R6
endmodule

bind opaddr_gen opaddr_gen_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NREG(NREG), .GREG_BYTES(GREG_BYTES),
  .IDX_W(IDX_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_valid_i  (req_valid_i),
  .ready_o      (ready_o),
  .mode_i       (mode_i),
  .idx_i        (idx_i),
  .dir_off_i    (dir_off_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_bytes_o  (mem_bytes_o),
  .beat_o       (beat_o),
  .last_o       (last_o),
  .ptr_wb_o     (ptr_wb_o),
  .ptr_wb_val_o (ptr_wb_val_o)
);

// File: tb/opaddr_gen_tb_top.sv
module opaddr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic        ready_o;
  logic [2:0]  mode_i = '0;
  logic [1:0]  idx_i = '0;
  logic [5:0]  dir_off_i = '0;
  logic [1:0]  width_i = '0;
  logic [15:0] ptr_val_i = '0;
  logic        blk_we_i = 1'b0;
  logic [9:0]  blk_val_i = '0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [2:0]  mem_bytes_o;
  logic [1:0]  beat_o;
  logic        last_o;
  logic        ptr_wb_o;
  logic [15:0] ptr_wb_addr_o;
  logic [15:0] ptr_wb_val_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  opaddr_gen dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .ready_o(ready_o),
    .mode_i(mode_i), .idx_i(idx_i), .dir_off_i(dir_off_i), .width_i(width_i),
    .ptr_val_i(ptr_val_i), .blk_we_i(blk_we_i), .blk_val_i(blk_val_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_bytes_o(mem_bytes_o),
    .beat_o(beat_o), .last_o(last_o), .ptr_wb_o(ptr_wb_o),
    .ptr_wb_addr_o(ptr_wb_addr_o), .ptr_wb_val_o(ptr_wb_val_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  bit    r_act = 0;
  int    r_addr = 0, r_bytes = 0, r_beat = 0, r_blk = 0;
  bit    r_wb = 0;
  int    r_wb_addr = 0, r_wb_val = 0;
  string r_tag = "R1";

  function automatic bit ref_ready();
    return !r_act || (r_beat + 1 == r_bytes);
  endfunction

  function automatic int width_count(int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    bit last_e = r_act && (r_beat + 1 == r_bytes);
    check(ready_o == ref_ready(), "R10", "ready_o", ready_o, ref_ready());
    check(mem_req_o == r_act, r_tag, "mem_req_o", mem_req_o, r_act);
    check(mem_addr_o == 16'(r_addr), r_tag, "mem_addr_o", mem_addr_o, r_addr);
    check(mem_bytes_o == 3'(r_bytes), r_tag, "mem_bytes_o", mem_bytes_o, r_bytes);
    check(beat_o == 2'(r_beat), "R9", "beat_o", beat_o, r_beat);
    check(last_o == last_e, "R9", "last_o", last_o, last_e);
    check(ptr_wb_o == r_wb, "R5", "ptr_wb_o", ptr_wb_o, r_wb);
    check(ptr_wb_addr_o == 16'(r_wb_addr), "R5", "ptr_wb_addr_o", ptr_wb_addr_o, r_wb_addr);
    check(ptr_wb_val_o == 16'(r_wb_val), "R5", "ptr_wb_val_o", ptr_wb_val_o, r_wb_val);
  endtask

  // inputs are already set (at the falling edge); model the rising edge
  task automatic step();
    int eff_blk = blk_we_i ? int'(blk_val_i) : r_blk;
    bit start = req_valid_i && ref_ready();
    bit was_act = r_act;
    if (blk_we_i) r_blk = int'(blk_val_i);
    r_wb = 0; r_wb_addr = 0; r_wb_val = 0;
    if (start) begin
      int m = int'(mode_i);
      int c = width_count(int'(width_i));
      int b = 0;
      case (m)
        0: begin b = 4 * int'(idx_i); r_tag = "R2"; end
        1: begin b = 16 + 2 * int'(idx_i); c = 2; r_tag = "R3"; end
        2: begin b = int'(ptr_val_i); r_tag = "R4"; end
        3: begin b = int'(ptr_val_i); r_tag = "R5"; end
        4: begin b = eff_blk * 64 + int'(dir_off_i); r_tag = blk_we_i ? "R7" : "R6"; end
        default: r_tag = "R8";
      endcase
      if (was_act && m <= 4) r_tag = "R11";
      if (m <= 4) begin
        r_act = 1; r_addr = b; r_bytes = c; r_beat = 0;
      end else begin
        r_act = 0; r_addr = 0; r_bytes = 0; r_beat = 0;
      end
      if (m == 3) begin
        r_wb = 1; r_wb_addr = 16 + 2 * int'(idx_i);
        r_wb_val = (int'(ptr_val_i) + c) % 65536;
      end
    end else if (r_act) begin
      if (r_beat + 1 == r_bytes) begin
        r_act = 0; r_addr = 0; r_bytes = 0; r_beat = 0;
      end else begin
        r_addr = (r_addr + 1) % 65536; r_beat++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    req_valid_i = 0; blk_we_i = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  // hold a request until the model shows it taken
  task automatic issue(int m, int idx, int off, int w, int ptr);
    mode_i = 3'(m); idx_i = 2'(idx); dir_off_i = 6'(off);
    width_i = 2'(w); ptr_val_i = 16'(ptr); req_valid_i = 1;
    for (int g = 0; g < 20; g++) begin
      bit took = ref_ready();
      step();
      blk_we_i = 0;
      if (took) break;
    end
    req_valid_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare(); // R1 reset state
    issue(4, 0, 6'h2A, 0, 0); idle(2);           // R1 block register starts at 0
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 4; k++) begin issue(0, k, 0, w, 0); idle(5); end // R2
    for (int k = 0; k < 4; k++) begin issue(1, k, 0, 0, 0); idle(3); end   // R3
    issue(2, 1, 0, 2, 16'h1234); idle(5);        // R4
    issue(3, 2, 0, 2, 16'hFFFE); idle(5);        // R5 wrap of the bumped pointer
    issue(3, 0, 0, 1, 16'h0100); idle(3);        // R5
    blk_we_i = 1; blk_val_i = 10'h155; idle(1);
    idle(1);
    issue(4, 0, 6'h3F, 1, 0); idle(3);           // R6
    blk_we_i = 1; blk_val_i = 10'h3FF;
    issue(4, 0, 6'h3F, 2, 0); idle(5);           // R7 same-cycle write, R9 address wrap
    issue(0, 3, 0, 2, 0);
    blk_we_i = 1; blk_val_i = 10'h00F; step(); blk_we_i = 0; // R7 write while busy
    idle(4);
    issue(4, 0, 6'h01, 0, 0); idle(2);           // R7 new block kept
    for (int m = 5; m < 8; m++) begin issue(m, 1, 0, 2, 16'h4444); idle(2); end // R8
    issue(0, 1, 0, 2, 0);
    mode_i = 3'd3; ptr_val_i = 16'h0777; req_valid_i = 1; step(); // R10 ignored while busy
    req_valid_i = 0; idle(4);
    issue(0, 2, 0, 2, 0); issue(2, 0, 0, 1, 16'h8000); issue(1, 3, 0, 0, 0); idle(4); // R11
    for (int i = 0; i < 600; i++) begin
      req_valid_i = 1'($urandom_range(0, 1));
      mode_i = 3'($urandom_range(0, 7));
      idx_i = 2'($urandom_range(0, 3));
      dir_off_i = 6'($urandom_range(0, 63));
      width_i = 2'($urandom_range(0, 3));
      ptr_val_i = 16'($urandom_range(0, 65535));
      blk_we_i = ($urandom_range(0, 9) == 0);
      blk_val_i = 10'($urandom_range(0, 1023));
      step();
    end
    idle(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule